// File: doc/BRIEF.md
# Circular Queue Pointer Manager

This block keeps the producer and consumer positions of a ring of fixed-size records that an I/O memory management unit holds in memory. It is used for both the command ring (16-byte records) and the event ring (32-byte records), with the record size picked by a parameter. Software sets the ring size at run time as a power of two (log2 form). The two sides then advance their positions with one-cycle strobes. The block reports whether the ring is full or empty, and it gives the byte address of the record each side points at next.

Each position is a counter with `log2size + 1` significant bits. The low `log2size` bits index a record, and the bit above them is a lap flag that flips on every pass around the ring. A 7-bit command error code sits in the consumer register at bits 30:24. A consumer step never disturbs it. Software reads and writes both positions through a small register port. All strobes are plain single-cycle pulses and are always accepted, so there is no back-pressure on any pin.

Top module: `cq_ptr_mgr`

## Requirements
- R1: After reset, both positions read zero, the error code is 0, the size setting is 0, and with the ring enabled `empty`=1 and `full`=0.
- R2: While enabled, `prod_inc` sets the producer position to (position + 1) masked to `log2size`+1 bits, so the lap flag toggles after each 2^log2size steps.
- R3: While enabled, `cons_inc` advances the consumer position in the same masked way. The error field in consumer bits 30:24 stays unchanged.
- R4: `full` is 1 exactly when (producer XOR consumer), masked to `log2size`+1 bits, equals 2^log2size.
- R5: `empty` is 1 exactly when producer and consumer agree on their low `log2size`+1 bits.
- R6: Each entry address is (`base_i` AND 0x000F_FFFF_FFFF_FFC0) + ENTRY_BYTES × (position AND (2^log2size − 1)).
- R7: A pulse on `err_wr` loads `err_code` into the error field. It shows on `cmd_err` and in consumer read bits 30:24 from the next cycle. Codes: 0 none, 1 illegal command, 2 abort, 3 invalidate-sync failure.
- R8: With `q_en`=0, both increment strobes are ignored, `empty` reads 1 and `full` reads 0.
- R9: A `cfg_wr` pulse loads `log2sz_i` and saturates it to 19, so any larger value becomes 19. The same pulse clears both positions and keeps the error field.
- R10: A register write (`reg_addr` 0 = producer, 1 = consumer) stores `reg_wdata` masked to `log2size`+1 bits. It wins over an increment on the same register in the same cycle. A read returns the position in the low bits; on the consumer it also returns the error field in bits 30:24, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_en | input | 1 | Ring enable (from the ring's enable bit in the control register) |
| base_i | input | 64 | Ring base address register |
| cfg_wr | input | 1 | Load size setting |
| log2sz_i | input | 5 | Requested log2 of ring depth |
| log2sz_o | output | 5 | Size setting in use |
| prod_inc | input | 1 | Producer step strobe |
| cons_inc | input | 1 | Consumer step strobe |
| reg_wr | input | 1 | Position register write strobe |
| reg_addr | input | 1 | 0 selects producer, 1 selects consumer |
| reg_wdata | input | 20 | Position write data |
| reg_rdata | output | 32 | Read data of the selected register |
| err_wr | input | 1 | Load command error code |
| err_code | input | 7 | Error code to load |
| cmd_err | output | 7 | Current command error code |
| full | output | 1 | Ring full |
| empty | output | 1 | Ring empty |
| prod_addr | output | 64 | Byte address of the producer's record |
| cons_addr | output | 64 | Byte address of the consumer's record |

## Verification
The assertions assume that the two sides never step past each other in a way that breaks the ring's meaning. They also assume that a size change happens only while no step of the same register is pending, because the step property compares positions under one mask. The stimulus follows this: every step sequence starts right after a size load, and steps never cross a `cfg_wr` pulse. The base address and error codes are driven freely, since no property constrains them.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int ERR_W   = 7;
  localparam int ERR_LSB = 24;
  localparam int RD_W    = 32;

  typedef enum logic [ERR_W-1:0] {
    CERR_NONE     = 7'd0,
    CERR_ILLEGAL  = 7'd1,
    CERR_ABORT    = 7'd2,
    CERR_ATC_SYNC = 7'd3
  } cq_err_e;

  typedef enum logic {
    SEL_PROD = 1'b0,
    SEL_CONS = 1'b1
  } cq_sel_e;
endpackage

// File: rtl/cq_size_cfg.sv
module cq_size_cfg #(
  parameter int MAX_LOG2 = 19,
  parameter int SZ_W     = $clog2(MAX_LOG2 + 1),
  parameter int PTR_W    = MAX_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [SZ_W-1:0]  log2sz_i,
  output logic [SZ_W-1:0]  l2,
  output logic [PTR_W-1:0] wrap_bit,
  output logic [PTR_W-1:0] idx_mask,
  output logic [PTR_W-1:0] wim
);
  localparam logic [SZ_W-1:0] L2_CAP = SZ_W'(MAX_LOG2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      l2 <= '0;
    else if (cfg_wr) l2 <= (log2sz_i > L2_CAP) ? L2_CAP : log2sz_i;
  end

  always_comb begin
    wrap_bit = PTR_W'(1) << l2;
    idx_mask = wrap_bit - PTR_W'(1);
    // at the largest size the shift wraps to zero and the subtraction gives all ones
    wim      = (wrap_bit << 1) - PTR_W'(1);
  end
endmodule

// File: rtl/cq_ptr.sv
module cq_ptr #(
  parameter int PTR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [PTR_W-1:0] wdata,
  input  logic             inc,
  input  logic [PTR_W-1:0] wim,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (clr) ptr <= '0;
    else if (wr)  ptr <= wdata & wim;
    else if (inc) ptr <= (ptr + PTR_W'(1)) & wim;
  end
endmodule

// File: rtl/cq_entry_addr.sv
module cq_entry_addr #(
  parameter int ADDR_W      = 64,
  parameter int PTR_W       = 20,
  parameter int BASE_HI     = 52,
  parameter int BASE_LO     = 6,
  parameter int ENTRY_BYTES = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [PTR_W-1:0]  idx_mask,
  output logic [ADDR_W-1:0] addr
);
  localparam int ENTRY_SH = $clog2(ENTRY_BYTES);
  localparam logic [ADDR_W-1:0] BASE_MASK =
    ((ADDR_W'(1) << BASE_HI) - ADDR_W'(1)) & ~((ADDR_W'(1) << BASE_LO) - ADDR_W'(1));

  always_comb addr = (base & BASE_MASK) + (ADDR_W'(ptr & idx_mask) << ENTRY_SH);
endmodule

// File: rtl/cq_ptr_mgr.sv
module cq_ptr_mgr
  import cq_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int MAX_LOG2    = 19,
  parameter int ENTRY_BYTES = 16,
  parameter int BASE_HI     = 52,
  parameter int BASE_LO     = 6,
  parameter int SZ_W        = $clog2(MAX_LOG2 + 1),
  parameter int PTR_W       = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_en,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              cfg_wr,
  input  logic [SZ_W-1:0]   log2sz_i,
  output logic [SZ_W-1:0]   log2sz_o,
  input  logic              prod_inc,
  input  logic              cons_inc,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [PTR_W-1:0]  reg_wdata,
  output logic [RD_W-1:0]   reg_rdata,
  input  logic              err_wr,
  input  logic [ERR_W-1:0]  err_code,
  output logic [ERR_W-1:0]  cmd_err,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] prod_addr,
  output logic [ADDR_W-1:0] cons_addr
);
  logic [PTR_W-1:0]  wrap_bit, idx_mask, wim;
  logic [PTR_W-1:0]  ptr_q [2];
  logic [ADDR_W-1:0] addr_w [2];
  logic [1:0]        inc_w;
  logic [ERR_W-1:0]  err_q;
  logic [PTR_W-1:0]  diff;

  cq_size_cfg #(.MAX_LOG2(MAX_LOG2), .SZ_W(SZ_W), .PTR_W(PTR_W)) u_size (
    .clk, .rst_n, .cfg_wr, .log2sz_i,
    .l2(log2sz_o), .wrap_bit, .idx_mask, .wim
  );

  assign inc_w = {cons_inc, prod_inc} & {2{q_en}};

  for (genvar s = 0; s < 2; s++) begin : g_side
    cq_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk, .rst_n, .clr(cfg_wr),
      .wr(reg_wr && (reg_addr == 1'(s))),
      .wdata(reg_wdata), .inc(inc_w[s]), .wim,
      .ptr(ptr_q[s])
    );
    cq_entry_addr #(
      .ADDR_W(ADDR_W), .PTR_W(PTR_W), .BASE_HI(BASE_HI),
      .BASE_LO(BASE_LO), .ENTRY_BYTES(ENTRY_BYTES)
    ) u_addr (
      .base(base_i), .ptr(ptr_q[s]), .idx_mask, .addr(addr_w[s])
    );
  end

  // error code is held apart from the consumer position so steps never reach it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= CERR_NONE;
    else if (err_wr) err_q <= err_code;
  end

  always_comb begin
    diff  = (ptr_q[SEL_PROD] ^ ptr_q[SEL_CONS]) & wim;
    full  = q_en && (diff == wrap_bit);
    empty = !q_en || (diff == '0);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == SEL_CONS) begin
      reg_rdata[PTR_W-1:0]       = ptr_q[SEL_CONS];
      reg_rdata[ERR_LSB +: ERR_W] = err_q;
    end else begin
      reg_rdata[PTR_W-1:0] = ptr_q[SEL_PROD];
    end
  end

  assign cmd_err   = err_q;
  assign prod_addr = addr_w[SEL_PROD];
  assign cons_addr = addr_w[SEL_CONS];
endmodule

// File: rtl/cq_ptr_mgr_chk.sv
module cq_ptr_mgr_chk #(
  parameter int ADDR_W      = 64,
  parameter int MAX_LOG2    = 19,
  parameter int ENTRY_BYTES = 16,
  parameter int SZ_W        = 5,
  parameter int PTR_W       = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              q_en,
  input logic              prod_inc,
  input logic              cons_inc,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic              cfg_wr,
  input logic              err_wr,
  input logic              full,
  input logic              empty,
  input logic [6:0]        cmd_err,
  input logic [SZ_W-1:0]   log2sz_o,
  input logic [PTR_W-1:0]  prod_q,
  input logic [PTR_W-1:0]  cons_q,
  input logic [PTR_W-1:0]  wim,
  input logic [ADDR_W-1:0] prod_addr,
  input logic [ADDR_W-1:0] cons_addr
);
  localparam int ENTRY_SH = $clog2(ENTRY_BYTES);

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R4

  AST_DISABLED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en |-> (empty && !full)); // R8

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_en && !reg_wr && !cfg_wr && (prod_inc || cons_inc)) |=> ($stable(prod_q) && $stable(cons_q))); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !err_wr |=> $stable(cmd_err)); // R3

  AST_SIZE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    log2sz_o <= SZ_W'(MAX_LOG2)); // R9

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((prod_q & ~wim) == '0) && ((cons_q & ~wim) == '0)); // R2

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_addr[ENTRY_SH-1:0] == '0) && (cons_addr[ENTRY_SH-1:0] == '0)); // R6

  AST_PROD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (q_en && prod_inc && !cfg_wr && !(reg_wr && !reg_addr))
      |=> (((prod_q - $past(prod_q)) & wim) == PTR_W'(1))); // R2
endmodule

bind cq_ptr_mgr cq_ptr_mgr_chk #(
  .ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2), .ENTRY_BYTES(ENTRY_BYTES),
  .SZ_W(SZ_W), .PTR_W(PTR_W)
) u_chk (
  .clk, .rst_n, .q_en, .prod_inc, .cons_inc, .reg_wr, .reg_addr,
  .cfg_wr, .err_wr, .full, .empty, .cmd_err, .log2sz_o,
  .prod_q(ptr_q[0]), .cons_q(ptr_q[1]), .wim, .prod_addr, .cons_addr
);

// File: tb/test_cq_ptr_mgr.sv
module test_cq_ptr_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W = 20;

  logic        clk = 0, rst_n = 0, q_en = 1;
  logic [63:0] base_i = 64'h0000_1234_5678_9A40;
  logic        cfg_wr = 0, prod_inc = 0, cons_inc = 0, reg_wr = 0, reg_addr = 0, err_wr = 0;
  logic [4:0]  log2sz_i = 0, log2sz_o;
  logic [PTR_W-1:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [6:0]  err_code = 0, cmd_err;
  logic        full, empty;
  logic [63:0] prod_addr, cons_addr;

  int n_chk = 0, n_fail = 0;
  int l2 = 0;
  longint ep = 0, ec = 0, ee = 0;

  cq_ptr_mgr i_cq_ptr_mgr (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint wmask();
    return (longint'(1) << (l2 + 1)) - 1;
  endfunction

  function automatic longint eaddr(longint p);
    return (base_i & 64'h000F_FFFF_FFFF_FFC0) + (p & ((longint'(1) << l2) - 1)) * 16;
  endfunction

  task automatic check_all(string tag);
    longint d;
    d = (ep ^ ec) & wmask();
    chk({tag, " R4 full"},  longint'(full),  q_en ? longint'(d == (longint'(1) << l2)) : 0);
    chk({tag, " R5 empty"}, longint'(empty), q_en ? longint'(d == 0) : 1);
    chk({tag, " R6 prod_addr"}, prod_addr, eaddr(ep));
    chk({tag, " R6 cons_addr"}, cons_addr, eaddr(ec));
    chk({tag, " R7 cmd_err"}, longint'(cmd_err), ee);
    reg_addr = 0; #1;
    chk({tag, " R10 prod read"}, longint'(reg_rdata), ep);
    reg_addr = 1; #1;
    chk({tag, " R10 cons read"}, longint'(reg_rdata), (ee << 24) | ec);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic step(bit pi, bit ci, string tag);
    prod_inc = pi; cons_inc = ci;
    tick();
    prod_inc = 0; cons_inc = 0;
    if (q_en) begin
      if (pi) ep = (ep + 1) & wmask();
      if (ci) ec = (ec + 1) & wmask();
    end
    check_all(tag);
  endtask

  task automatic set_size(int v);
    cfg_wr = 1; log2sz_i = 5'(v);
    tick();
    cfg_wr = 0;
    l2 = (v > 19) ? 19 : v;
    ep = 0; ec = 0;
    chk("R9 size", longint'(log2sz_o), l2);
    check_all("R9");
  endtask

  task automatic wreg(bit a, longint d, bit pi, bit ci);
    reg_wr = 1; reg_addr = a; reg_wdata = PTR_W'(d); prod_inc = pi; cons_inc = ci;
    tick();
    reg_wr = 0; prod_inc = 0; cons_inc = 0;
    if (a == 0) begin
      ep = d & wmask();
      if (q_en && ci) ec = (ec + 1) & wmask();
    end else begin
      ec = d & wmask();
      if (q_en && pi) ep = (ep + 1) & wmask();
    end
    check_all("R10");
  endtask

  task automatic set_err(int c);
    err_wr = 1; err_code = 7'(c);
    tick();
    err_wr = 0;
    ee = c;
    check_all("R7");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("R1 size", longint'(log2sz_o), 0);
    check_all("R1");

    for (int s = 0; s <= 3; s++) begin
      set_size(s);
      for (int i = 0; i < (2 << s) + 1; i++) step(1, 0, "R2");
      for (int i = 0; i < (2 << s) + 1; i++) step(0, 1, "R3");
      for (int i = 0; i < 8; i++) step(i % 2 == 0, i % 3 == 0, "R2 mixed");
    end

    set_size(2);
    for (int i = 0; i < 4; i++) step(1, 0, "R4 fill");
    set_err(2);
    for (int i = 0; i < 5; i++) step(0, 1, "R3 err kept");
    set_err(3);
    set_err(1);

    q_en = 0; #1;
    check_all("R8");
    step(1, 0, "R8");
    step(0, 1, "R8");
    step(1, 1, "R8");
    q_en = 1; #1;
    check_all("R8 reenable");

    set_size(25);
    set_size(31);
    set_size(19);
    wreg(0, 64'h80000, 0, 0);
    wreg(1, 0, 0, 0);
    step(0, 1, "R3 large");
    set_size(2);
    wreg(0, 64'hFFFFF, 0, 0);
    wreg(0, 2, 1, 0);
    wreg(1, 5, 0, 1);
    wreg(1, 1, 1, 0);

    base_i = 64'hFFFF_FFFF_FFFF_FFFF; #1;
    check_all("R6 base mask");
    for (int i = 0; i < 4; i++) step(1, 1, "R6");
    base_i = 64'h0000_0000_0000_003F; #1;
    check_all("R6 low base");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule